// File: doc/BRIEF.md
# Character-Synchronous Transmit Framer

This block turns byte messages into a serial line stream for a byte-oriented synchronous link. Once enabled, it keeps the line busy between messages. It does this either with repeating two-character sync pairs or with all-ones idle characters, as configured. Message bytes arrive one at a time over a descriptor-style interface. Each byte carries the flags of its buffer: end of buffer, last buffer of a block, block check wanted, and interrupt wanted. The framer pulls a byte with a one-cycle take strobe at the moment it loads that byte into the shifter. A message always starts right after a complete sync pair.

When the last buffer of a block asks for a block check, the framer appends one. The check is either a CRC16 (polynomial x^16+x^15+x^2+1, zero start value, low byte sent first) or a single-byte longitudinal XOR. The check spans every buffer of the block. In transparent mode, any data byte equal to the escape code 0x10 is preceded by an inserted 0x10. The inserted escape and the byte it protects leave back to back, and the escape is not counted in the block check. Optional even parity can overwrite bit 7 of each data byte. The bit order within each character is selectable. The framer pulses a completion strobe per buffer, an interrupt strobe for flagged buffers, and an underrun strobe when a block starves.

Top module: `bsc_tx_framer`

## Requirements
- R1: While reset is held or the enable input is low, ser_out is 1. One clock after the enable input falls, ser_out is 1.
- R2: With no message pending, the line repeats the sync pair cfg_syn1 then cfg_syn2 when cfg_fill_sync is 1. When cfg_fill_sync is 0, it sends characters of 0xFF.
- R3: A message's first data character immediately follows a complete cfg_syn1, cfg_syn2 pair. This holds even when the line was idling with 0xFF.
- R4: Each character takes 8 clocks and is sent bit 0 first when cfg_rev is 0 and bit 7 first when cfg_rev is 1.
- R5: When the buffer that ends a block has buf_last and buf_bcs set and cfg_crc16 is 0, one character equal to the XOR of all block data characters (as transmitted) follows the last data character.
- R6: With cfg_crc16 at 1, two characters follow instead: the CRC16 of the block's transmitted data characters, low byte first. The CRC runs across all buffers of the block.
- R7: With cfg_transp at 1, a data byte equal to 0x10 is sent as 0x10 0x10. Only one take is counted for it, the inserted escape is left out of the block check, and the two characters are never separated.
- R8: With cfg_vrc at 1, bit 7 of each data character is replaced by the even parity of bits 6:0.
- R9: bd_done pulses once per buffer. For a buffer with no trailer, the pulse comes when its end byte is taken. For a buffer with a trailer, it comes when the trailer's final character is loaded. bd_irq pulses with it only when that buffer's buf_irq is set.
- R10: After a block ends, the line carries sync pairs if cfg_end_sync is 1 and 0xFF characters if it is 0.
- R11: If no byte is valid when the next character of an unfinished block is due, tx_underrun pulses once and the line reverts to sync pairs.
- R12: buf_take pulses exactly once per consumed data byte and only while buf_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmitter enable |
| cfg_fill_sync | input | 1 | Fill before the first block: 1 sync pairs, 0 all-ones |
| cfg_end_sync | input | 1 | Fill after a block: 1 sync pairs, 0 all-ones |
| cfg_transp | input | 1 | Transparent mode with escape insertion |
| cfg_crc16 | input | 1 | Block check type: 1 CRC16, 0 XOR byte |
| cfg_vrc | input | 1 | Even parity into data bit 7 |
| cfg_rev | input | 1 | Send characters MSB first |
| cfg_syn1 | input | 8 | First sync character |
| cfg_syn2 | input | 8 | Second sync character |
| buf_valid | input | 1 | A message byte is available |
| buf_data | input | 8 | Message byte |
| buf_end | input | 1 | This byte ends its buffer |
| buf_last | input | 1 | The buffer ends the block (valid with buf_end) |
| buf_bcs | input | 1 | Append block check (valid with buf_end) |
| buf_irq | input | 1 | Interrupt on completion of this buffer |
| buf_take | output | 1 | Byte consumed this cycle |
| ser_out | output | 1 | Serial line |
| bd_done | output | 1 | Buffer completed pulse |
| bd_irq | output | 1 | Buffer interrupt pulse |
| tx_underrun | output | 1 | Block starved pulse |

## Verification
Two functions can fall on the same character boundary. The first is the block check seeing a byte that the transparent escape logic is also rewriting. The second is the end-of-block path, where trailer loading and buffer completion coincide. The transparent test sends a block that both begins and ends with the escape value and has a CRC trailer. It is judged by comparing the captured line characters against an expected stream built with a CRC over the unescaped bytes only, and by counting takes. A two-buffer test with a trailer checks that the completion and interrupt pulses of the first buffer arrive on their own, and that the trailer then completes the second buffer.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int CHAR_W = 8;
    localparam int BCS_W  = 16;
    localparam logic [BCS_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [2:0] {
        K_NONE, K_IDLE, K_SYN1, K_SYN2, K_ESC, K_DATA, K_BC1, K_BC2
    } ch_kind_e;

    typedef enum logic [1:0] {
        T_MORE, T_END, T_TRAIL
    } tail_e;

    typedef struct packed {
        ch_kind_e            kind;
        logic [CHAR_W-1:0]   code;
    } tx_char_t;

    function automatic logic [BCS_W-1:0] crc16_step(input logic [BCS_W-1:0] c,
                                                    input logic [CHAR_W-1:0] d);
        logic [BCS_W-1:0] r;
        r = c ^ {{(BCS_W-CHAR_W){1'b0}}, d};
        for (int i = 0; i < CHAR_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [CHAR_W-1:0] vrc_apply(input logic [CHAR_W-1:0] d);
        return {^d[CHAR_W-2:0], d[CHAR_W-2:0]};
    endfunction

endpackage

// File: rtl/bsc_bcs_acc.sv
module bsc_bcs_acc
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [CHAR_W-1:0] din,
    output logic [BCS_W-1:0]  crc,
    output logic [CHAR_W-1:0] lrc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
            lrc <= '0;
        end else if (upd) begin
            crc <= crc16_step(crc, din);
            lrc <= lrc ^ din;
        end
    end
endmodule

// File: rtl/bsc_serializer.sv
module bsc_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         rev,
    input  logic [W-1:0] char_in,
    output logic         ld,
    output logic         ser_out
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;
    logic          act;
    logic          bit_sel;

    assign ld = en && (!act || cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            act <= 1'b0;
            cnt <= '0;
            sh  <= '0;
        end else if (ld) begin
            sh  <= char_in;
            cnt <= '0;
            act <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        bit_sel = rev ? sh[LAST - cnt] : sh[cnt];
        ser_out = act ? bit_sel : 1'b1;
    end
endmodule

// File: rtl/bsc_tx_seq.sv
module bsc_tx_seq
    import bsc_pkg::*;
#(
    parameter logic [CHAR_W-1:0] DLE_CODE = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ld,
    input  logic              cfg_fill_sync,
    input  logic              cfg_end_sync,
    input  logic              cfg_transp,
    input  logic              cfg_crc16,
    input  logic              cfg_vrc,
    input  logic [CHAR_W-1:0] cfg_syn1,
    input  logic [CHAR_W-1:0] cfg_syn2,
    input  logic              buf_valid,
    input  logic [CHAR_W-1:0] buf_data,
    input  logic              buf_end,
    input  logic              buf_last,
    input  logic              buf_bcs,
    input  logic              buf_irq,
    input  logic [BCS_W-1:0]  crc,
    input  logic [CHAR_W-1:0] lrc,
    output tx_char_t          nxt_char,
    output ch_kind_e          kind_q,
    output logic              take,
    output logic              done,
    output logic              irq,
    output logic              underrun,
    output logic              bc_clr,
    output logic [CHAR_W-1:0] bc_din
);
    tail_e             tail_q;
    logic              mode_sync;
    logic              irq_q;
    ch_kind_e          nxt, fill_k, end_k, msg_k;
    logic [CHAR_W-1:0] tx_data;
    logic              fin_bd, fin_tr, blk_end;

    always_comb begin
        fill_k  = mode_sync ? K_SYN1 : K_IDLE;
        end_k   = cfg_end_sync ? K_SYN1 : K_IDLE;
        msg_k   = (cfg_transp && buf_data == DLE_CODE) ? K_ESC : K_DATA;
        tx_data = cfg_vrc ? vrc_apply(buf_data) : buf_data;
        unique case (kind_q)
            K_NONE, K_IDLE: nxt = (buf_valid || mode_sync) ? K_SYN1 : K_IDLE;
            K_SYN1:         nxt = K_SYN2;
            K_SYN2:         nxt = buf_valid ? msg_k : fill_k;
            K_ESC:          nxt = K_DATA;
            K_DATA: begin
                unique case (tail_q)
                    T_TRAIL: nxt = K_BC1;
                    T_END:   nxt = end_k;
                    default: nxt = buf_valid ? msg_k : K_SYN1;
                endcase
            end
            K_BC1:          nxt = cfg_crc16 ? K_BC2 : end_k;
            default:        nxt = end_k;
        endcase

        nxt_char.kind = nxt;
        unique case (nxt)
            K_SYN1:  nxt_char.code = cfg_syn1;
            K_SYN2:  nxt_char.code = cfg_syn2;
            K_ESC:   nxt_char.code = DLE_CODE;
            K_DATA:  nxt_char.code = tx_data;
            K_BC1:   nxt_char.code = cfg_crc16 ? crc[CHAR_W-1:0] : lrc;
            K_BC2:   nxt_char.code = crc[BCS_W-1:CHAR_W];
            default: nxt_char.code = '1;
        endcase

        take     = ld && nxt == K_DATA;
        fin_bd   = take && buf_end && !(buf_last && buf_bcs);
        fin_tr   = ld && ((nxt == K_BC1 && !cfg_crc16) || nxt == K_BC2);
        done     = fin_bd || fin_tr;
        irq      = (fin_bd && buf_irq) || (fin_tr && irq_q);
        underrun = ld && kind_q == K_DATA && tail_q == T_MORE && !buf_valid;
        blk_end  = (ld && kind_q == K_DATA && tail_q == T_END) || fin_tr;
        bc_clr   = ld && (nxt == K_SYN1 || nxt == K_IDLE);
        bc_din   = tx_data;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            kind_q    <= K_NONE;
            tail_q    <= T_MORE;
            mode_sync <= cfg_fill_sync;
            irq_q     <= 1'b0;
        end else if (ld) begin
            kind_q <= nxt;
            if (take) begin
                irq_q <= buf_irq;
                if (buf_end && buf_last)
                    tail_q <= buf_bcs ? T_TRAIL : T_END;
                else
                    tail_q <= T_MORE;
            end
            if (blk_end)
                mode_sync <= cfg_end_sync;
        end
    end
endmodule

// File: rtl/bsc_tx_framer.sv
module bsc_tx_framer
    import bsc_pkg::*;
#(
    parameter logic [7:0] DLE_CODE = 8'h10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_en,
    input  logic       cfg_fill_sync,
    input  logic       cfg_end_sync,
    input  logic       cfg_transp,
    input  logic       cfg_crc16,
    input  logic       cfg_vrc,
    input  logic       cfg_rev,
    input  logic [7:0] cfg_syn1,
    input  logic [7:0] cfg_syn2,
    input  logic       buf_valid,
    input  logic [7:0] buf_data,
    input  logic       buf_end,
    input  logic       buf_last,
    input  logic       buf_bcs,
    input  logic       buf_irq,
    output logic       buf_take,
    output logic       ser_out,
    output logic       bd_done,
    output logic       bd_irq,
    output logic       tx_underrun
);
    logic              ld;
    tx_char_t          nxt_char;
    ch_kind_e          kind_q;
    logic              bc_clr;
    logic [CHAR_W-1:0] bc_din;
    logic [BCS_W-1:0]  crc;
    logic [CHAR_W-1:0] lrc;

    bsc_tx_seq #(.DLE_CODE(DLE_CODE)) seq_i (
        .clk(clk), .rst(rst), .en(cfg_en), .ld(ld),
        .cfg_fill_sync(cfg_fill_sync), .cfg_end_sync(cfg_end_sync),
        .cfg_transp(cfg_transp), .cfg_crc16(cfg_crc16), .cfg_vrc(cfg_vrc),
        .cfg_syn1(cfg_syn1), .cfg_syn2(cfg_syn2),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_end(buf_end),
        .buf_last(buf_last), .buf_bcs(buf_bcs), .buf_irq(buf_irq),
        .crc(crc), .lrc(lrc),
        .nxt_char(nxt_char), .kind_q(kind_q),
        .take(buf_take), .done(bd_done), .irq(bd_irq), .underrun(tx_underrun),
        .bc_clr(bc_clr), .bc_din(bc_din)
    );

    bsc_bcs_acc bcs_i (
        .clk(clk), .rst(rst), .clr(bc_clr), .upd(buf_take),
        .din(bc_din), .crc(crc), .lrc(lrc)
    );

    bsc_serializer #(.W(CHAR_W)) ser_i (
        .clk(clk), .rst(rst), .en(cfg_en), .rev(cfg_rev),
        .char_in(nxt_char.code), .ld(ld), .ser_out(ser_out)
    );
endmodule

// File: rtl/bsc_tx_framer_chk.sv
module bsc_tx_framer_chk
    import bsc_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cfg_en,
    input logic     ser_out,
    input logic     buf_valid,
    input logic     buf_take,
    input logic     bd_done,
    input logic     bd_irq,
    input logic     tx_underrun,
    input logic     ld,
    input ch_kind_e kind_q
);
    a_r1_line_mark: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> ser_out);

    a_r12_take_valid: assert property (@(posedge clk) disable iff (rst)
        buf_take |-> buf_valid);

    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        bd_irq |-> bd_done);

    a_r11_underrun_alone: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |-> (!buf_take && !bd_done));

    a_r7_escape_pair: assert property (@(posedge clk) disable iff (rst)
        (ld && kind_q == K_ESC) |-> buf_take);

    a_r3_pair_first: assert property (@(posedge clk) disable iff (rst)
        (ld && (kind_q == K_NONE || kind_q == K_IDLE || kind_q == K_SYN1 ||
                kind_q == K_BC1 || kind_q == K_BC2)) |-> !buf_take);
endmodule

bind bsc_tx_framer bsc_tx_framer_chk chk_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .ser_out(ser_out),
    .buf_valid(buf_valid), .buf_take(buf_take), .bd_done(bd_done),
    .bd_irq(bd_irq), .tx_underrun(tx_underrun), .ld(ld), .kind_q(kind_q)
);

// File: tb/bsc_tx_framer_tb.sv
module bsc_tx_framer_tb_top;
    localparam logic [7:0] S1 = 8'h16;
    localparam logic [7:0] S2 = 8'h2D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 0, cfg_fill_sync = 1, cfg_end_sync = 1, cfg_transp = 0;
    logic cfg_crc16 = 0, cfg_vrc = 0, cfg_rev = 0;
    logic buf_take, ser_out, bd_done, bd_irq, tx_underrun;

    logic [7:0] bd_data [32];
    logic       bd_end [32], bd_last [32], bd_bcs [32], bd_irqf [32];
    int         n_bd = 0;
    logic [4:0] idx;

    int tests = 0, fails = 0;
    int take_n, done_n, irq_n, und_n;
    logic en_seen;
    logic [7:0] cap [256];
    int cap_n, bitc;
    logic [7:0] acc;
    logic [7:0] exp_c [64];
    int exp_n;

    always #4 clk = ~clk;

    wire buf_valid = (int'(idx) < n_bd);

    bsc_tx_framer dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_fill_sync(cfg_fill_sync),
        .cfg_end_sync(cfg_end_sync), .cfg_transp(cfg_transp), .cfg_crc16(cfg_crc16),
        .cfg_vrc(cfg_vrc), .cfg_rev(cfg_rev), .cfg_syn1(S1), .cfg_syn2(S2),
        .buf_valid(buf_valid), .buf_data(bd_data[idx]), .buf_end(bd_end[idx]),
        .buf_last(bd_last[idx]), .buf_bcs(bd_bcs[idx]), .buf_irq(bd_irqf[idx]),
        .buf_take(buf_take), .ser_out(ser_out), .bd_done(bd_done),
        .bd_irq(bd_irq), .tx_underrun(tx_underrun)
    );

    always @(posedge clk) begin
        if (rst) begin
            idx <= '0; en_seen <= 1'b0;
            take_n <= 0; done_n <= 0; irq_n <= 0; und_n <= 0;
        end else begin
            en_seen <= cfg_en;
            if (buf_take) begin idx <= idx + 1'b1; take_n <= take_n + 1; end
            if (bd_done) done_n <= done_n + 1;
            if (bd_irq) irq_n <= irq_n + 1;
            if (tx_underrun) und_n <= und_n + 1;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            cap_n = 0; bitc = 0; acc = '0;
        end else if (en_seen) begin
            if (cfg_rev) acc[7-bitc] = ser_out; else acc[bitc] = ser_out;
            bitc++;
            if (bitc == 8) begin
                if (cap_n < 256) cap[cap_n] = acc;
                cap_n++;
                bitc = 0;
            end
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb = r[0] ^ d[k];
            r = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic ex(input logic [7:0] c);
        exp_c[exp_n] = c; exp_n++;
    endtask

    task automatic chk_seq(input string req, input bit skip_ff);
        int st = 0;
        if (skip_ff) while (st < cap_n && cap[st] == 8'hFF) st++;
        check({req, " length"}, (cap_n >= st + exp_n) ? 1 : 0, 1);
        for (int i = 0; i < exp_n; i++)
            if (st + i < cap_n) check(req, cap[st+i], exp_c[i]);
    endtask

    task automatic add_bd(input logic [7:0] d, input logic e, input logic l,
                          input logic b, input logic q);
        bd_data[n_bd] = d; bd_end[n_bd] = e; bd_last[n_bd] = l;
        bd_bcs[n_bd] = b; bd_irqf[n_bd] = q; n_bd++;
    endtask

    task automatic start(input logic fs, input logic es);
        @(negedge clk);
        rst = 1; cfg_en = 0; n_bd = 0;
        cfg_fill_sync = fs; cfg_end_sync = es; cfg_transp = 0;
        cfg_crc16 = 0; cfg_vrc = 0; cfg_rev = 0; exp_n = 0;
        for (int i = 0; i < 32; i++) begin
            bd_data[i] = '0; bd_end[i] = 0; bd_last[i] = 0; bd_bcs[i] = 0; bd_irqf[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic run(input int cyc);
        cfg_en = 1;
        repeat (cyc) @(negedge clk);
        cfg_en = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        int hi = 1;
        start(1, 1);
        repeat (10) begin @(negedge clk); if (!ser_out) hi = 0; end
        check("R1 disabled line high", hi, 1);
        check("R12 no take while disabled", take_n, 0);
        cfg_en = 1;
        repeat (37) @(negedge clk);
        cfg_en = 0;
        @(negedge clk);
        check("R1 line high after disable", ser_out, 1);
    endtask

    task automatic t_sync_fill;
        start(1, 1);
        run(48);
        ex(S1); ex(S2); ex(S1); ex(S2);
        chk_seq("R2 sync pair fill", 0);
    endtask

    task automatic t_idle_msg;
        start(0, 0);
        cfg_en = 1;
        repeat (24) @(negedge clk);
        add_bd(8'h41, 0, 0, 0, 1);
        add_bd(8'h42, 1, 1, 0, 1);
        repeat (80) @(negedge clk);
        cfg_en = 0;
        repeat (2) @(negedge clk);
        check("R2 idle fill 0xFF", cap[0], 8'hFF);
        ex(S1); ex(S2); ex(8'h41); ex(8'h42); ex(8'hFF);
        chk_seq("R3 R10 pair then data then idle", 1);
        check("R9 done count", done_n, 1);
        check("R9 irq count", irq_n, 1);
        check("R12 take count", take_n, 2);
    endtask

    task automatic t_lrc;
        logic [7:0] x = '0;
        logic [7:0] d [5] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
        start(1, 1);
        for (int i = 0; i < 5; i++) begin
            add_bd(d[i], i == 4, i == 4, i == 4, 0);
            x ^= d[i];
        end
        run(120);
        ex(S1); ex(S2);
        for (int i = 0; i < 5; i++) ex(d[i]);
        ex(x); ex(S1); ex(S2);
        chk_seq("R5 R10 xor trailer then sync", 0);
        check("R9 no irq when unflagged", irq_n, 0);
    endtask

    task automatic t_crc;
        logic [15:0] c = '0;
        start(1, 1);
        cfg_crc16 = 1;
        add_bd(8'h01, 0, 0, 0, 0);
        add_bd(8'h02, 1, 0, 0, 0);
        add_bd(8'h03, 1, 1, 1, 1);
        c = ref_crc(c, 8'h01); c = ref_crc(c, 8'h02); c = ref_crc(c, 8'h03);
        run(100);
        ex(S1); ex(S2); ex(8'h01); ex(8'h02); ex(8'h03); ex(c[7:0]); ex(c[15:8]); ex(S1);
        chk_seq("R6 crc across buffers", 0);
        check("R9 done per buffer", done_n, 2);
        check("R9 irq only flagged", irq_n, 1);
    endtask

    task automatic t_transp;
        logic [15:0] c = '0;
        start(1, 1);
        cfg_transp = 1; cfg_crc16 = 1;
        add_bd(8'h10, 0, 0, 0, 0);
        add_bd(8'h55, 0, 0, 0, 0);
        add_bd(8'h10, 1, 1, 1, 0);
        c = ref_crc(c, 8'h10); c = ref_crc(c, 8'h55); c = ref_crc(c, 8'h10);
        run(120);
        ex(S1); ex(S2); ex(8'h10); ex(8'h10); ex(8'h55); ex(8'h10); ex(8'h10);
        ex(c[7:0]); ex(c[15:8]); ex(S1);
        chk_seq("R7 escape insertion and crc", 0);
        check("R7 one take per escaped byte", take_n, 3);
        check("R11 no underrun in escape", und_n, 0);
    endtask

    task automatic t_parity;
        start(1, 0);
        cfg_vrc = 1;
        add_bd(8'h01, 0, 0, 0, 0);
        add_bd(8'h83, 0, 0, 0, 0);
        add_bd(8'h07, 1, 1, 1, 0);
        run(90);
        ex(S1); ex(S2); ex(8'h81); ex(8'h03); ex(8'h87); ex(8'h81 ^ 8'h03 ^ 8'h87); ex(8'hFF);
        chk_seq("R8 R10 parity bit7 then idle", 0);
    endtask

    task automatic t_rev;
        start(1, 0);
        cfg_rev = 1;
        add_bd(8'hC5, 0, 0, 0, 0);
        add_bd(8'h3A, 1, 1, 0, 0);
        run(60);
        ex(S1); ex(S2); ex(8'hC5); ex(8'h3A); ex(8'hFF);
        chk_seq("R4 msb first order", 0);
    endtask

    task automatic t_under;
        start(1, 1);
        add_bd(8'hA1, 0, 0, 0, 0);
        add_bd(8'hA2, 1, 0, 0, 1);
        run(60);
        ex(S1); ex(S2); ex(8'hA1); ex(8'hA2); ex(S1); ex(S2);
        chk_seq("R11 starve reverts to sync", 0);
        check("R11 underrun count", und_n, 1);
        check("R9 done on non-last buffer", done_n, 1);
        check("R9 irq on non-last buffer", irq_n, 1);
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_fill();
        t_idle_msg();
        t_lrc();
        t_crc();
        t_transp();
        t_parity();
        t_rev();
        t_under();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule